// File: doc/BRIEF.md
# Up/Down Counter with Falling-Edge Capture

A 16-bit counter that advances by one on each single-cycle count tick while the run control is high, incrementing or decrementing according to a direction select. A wrap in either direction (0xFFFF to 0x0000 going up, 0x0000 to 0xFFFF going down) sets one shared sticky wrap flag.

An asynchronous capture pin is brought into the clock domain through a two-flop synchronizer. A falling edge on it snapshots the live count into a capture register and sets a sticky capture flag. This happens only when the capture enable, the capture mode select and the run control are all high.

Each flag has its own interrupt enable, and the enabled flags are ORed into one interrupt request. Software clears each flag with its own one-cycle clear strobe.

Top module: `cap_timer`

## Requirements
- R1: While run_i is 1, each cycle with tick_i = 1 increments count_o by one when dec_i = 0 and decrements it by one when dec_i = 1. The new value is visible after the next rising clock edge.
- R2: An increment from 0xFFFF produces 0x0000 and sets wrap_flag_o.
- R3: A decrement from 0x0000 produces 0xFFFF and sets the same wrap_flag_o.
- R4: If cap_pin_i is sampled 1 at clock edge k-1 and 0 at edge k, then at edge k+2 cap_val_o is loaded with the count_o value held just before edge k+2. This holds even when a tick updates the count at that same edge.
- R5: Every capture sets cap_flag_o. A later falling edge captures again and overwrites cap_val_o even while the flag is still set.
- R6: While cap_en_i = 0, edges on cap_pin_i change neither cap_val_o nor cap_flag_o.
- R7: A capture needs cap_mode_i = 1 and run_i = 1 in the strobe cycle, otherwise the edge is ignored. While run_i = 0, ticks leave count_o unchanged.
- R8: irq_o = (wrap_flag_o AND wrap_ie_i) OR (cap_flag_o AND cap_ie_i), evaluated combinationally.
- R9: A flag stays 1 until its clear strobe (wrap_clr_i, cap_clr_i) is 1 at a clock edge. A set event at the same edge as a clear wins, and the flag stays 1.
- R10: Asynchronous reset (rst_ni = 0) forces count_o, cap_val_o, both flags and irq_o to 0.
- R11: The synchronizer resets to 0, so a capture pin held low from reset produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run control: counting and capture allowed |
| cap_en_i | input | 1 | Capture enable for the external pin |
| dec_i | input | 1 | Direction: 1 counts down, 0 counts up |
| cap_mode_i | input | 1 | Mode select: 1 selects capture mode |
| tick_i | input | 1 | Single-cycle count event |
| cap_pin_i | input | 1 | Asynchronous capture pin, falling edge active |
| wrap_ie_i | input | 1 | Interrupt enable for the wrap flag |
| cap_ie_i | input | 1 | Interrupt enable for the capture flag |
| wrap_clr_i | input | 1 | Clear strobe for the wrap flag |
| cap_clr_i | input | 1 | Clear strobe for the capture flag |
| count_o | output | 16 | Live count |
| cap_val_o | output | 16 | Captured count |
| wrap_flag_o | output | 1 | Sticky overflow/underflow flag |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a capture strobe and a count tick. The bench keeps tick_i high every cycle while the pin falls, and expects the pre-tick count, two edges after the synchronized fall.

The second pair is a flag set event and its clear strobe. The bench drives a wrapping tick together with wrap_clr_i and expects the flag to remain 1.

A scoreboard model derived from the requirements predicts count, capture value, flags and interrupt for every cycle, and compares them just after each clock edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int FLG_WRAP = 0;
  localparam int FLG_CAP  = 1;
  localparam int NUM_FLG  = 2;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] chain_q;  // [STAGES-1:0] sync, [STAGES] previous sample

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/updown_cnt.sv
module updown_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= dec_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  assign wrap_o = en_i & (dec_i ? (cnt_q == '0) : (cnt_q == ALL_ONES));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= 1'b0;
    else if (set_i) q <= 1'b1;  // set beats clear
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cap_en_i,
  input  logic             dec_i,
  input  logic             cap_mode_i,
  input  logic             tick_i,
  input  logic             cap_pin_i,
  input  logic             wrap_ie_i,
  input  logic             cap_ie_i,
  input  logic             wrap_clr_i,
  input  logic             cap_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             wrap_flag_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic             fall;
  logic             cnt_adv;
  logic             cnt_wrap;
  logic             cap_fire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_q;

  logic [NUM_FLG-1:0] flg_set, flg_clr, flg_ie, flg_q;

  cap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .fall_o (fall)
  );

  assign cnt_adv = run_i & tick_i;

  updown_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_adv),
    .dec_i  (dec_i),
    .cnt_o  (cnt),
    .wrap_o (cnt_wrap)
  );

  assign cap_fire = fall & cap_en_i & cap_mode_i & run_i;

  // snapshot takes the pre-update count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= '0;
    else if (cap_fire) cap_q <= cnt;
  end

  assign flg_set[FLG_WRAP] = cnt_wrap;
  assign flg_set[FLG_CAP]  = cap_fire;
  assign flg_clr[FLG_WRAP] = wrap_clr_i;
  assign flg_clr[FLG_CAP]  = cap_clr_i;
  assign flg_ie[FLG_WRAP]  = wrap_ie_i;
  assign flg_ie[FLG_CAP]   = cap_ie_i;

  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
    sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flg_set[g]),
      .clr_i  (flg_clr[g]),
      .q_o    (flg_q[g])
    );
  end

  assign count_o     = cnt;
  assign cap_val_o   = cap_q;
  assign wrap_flag_o = flg_q[FLG_WRAP];
  assign cap_flag_o  = flg_q[FLG_CAP];
  assign irq_o       = |(flg_q & flg_ie);
endmodule

module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cap_en_i,
  input logic             dec_i,
  input logic             tick_i,
  input logic             wrap_ie_i,
  input logic             cap_ie_i,
  input logic             wrap_clr_i,
  input logic             cap_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             wrap_flag_o,
  input logic             cap_flag_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  a_r1_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !dec_i |=> count_o == $past(count_o) + 1'b1);

  a_r1_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && dec_i |=> count_o == $past(count_o) - 1'b1);

  a_r7_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_o));

  a_r2_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !dec_i && count_o == MAXV |=> wrap_flag_o);

  a_r3_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && dec_i && count_o == '0 |=> wrap_flag_o);

  a_r6_no_cap_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(cap_val_o));

  a_r9_wrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_flag_o && !wrap_clr_i |=> wrap_flag_o);

  a_r9_cap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_flag_o && !cap_clr_i |=> cap_flag_o);

  a_r8_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((wrap_flag_o && wrap_ie_i) || (cap_flag_o && cap_ie_i)));
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .cap_en_i    (cap_en_i),
  .dec_i       (dec_i),
  .tick_i      (tick_i),
  .wrap_ie_i   (wrap_ie_i),
  .cap_ie_i    (cap_ie_i),
  .wrap_clr_i  (wrap_clr_i),
  .cap_clr_i   (cap_clr_i),
  .count_o     (count_o),
  .cap_val_o   (cap_val_o),
  .wrap_flag_o (wrap_flag_o),
  .cap_flag_o  (cap_flag_o),
  .irq_o       (irq_o)
);

// File: tb/sim_cap_timer.sv
`timescale 1ns/1ps
module sim_cap_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic run, cen, dec, mode, tick, pin, wie, cie, wclr, cclr;
  } stim_t;

  typedef struct {
    string       tag;
    logic [15:0] cnt;
    logic [15:0] cap;
    logic        wf;
    logic        cf;
    logic        irq;
  } exp_t;

  stim_t nx, cur;
  exp_t  sb_q[$];

  logic [15:0] count, cap_val;
  logic        wrap_flag, cap_flag, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cap_timer u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .run_i       (cur.run),
    .cap_en_i    (cur.cen),
    .dec_i       (cur.dec),
    .cap_mode_i  (cur.mode),
    .tick_i      (cur.tick),
    .cap_pin_i   (cur.pin),
    .wrap_ie_i   (cur.wie),
    .cap_ie_i    (cur.cie),
    .wrap_clr_i  (cur.wclr),
    .cap_clr_i   (cur.cclr),
    .count_o     (count),
    .cap_val_o   (cap_val),
    .wrap_flag_o (wrap_flag),
    .cap_flag_o  (cap_flag),
    .irq_o       (irq)
  );

  // reference model state
  logic [15:0] m_cnt = '0, m_cap = '0;
  logic        m_wf = 1'b0, m_cf = 1'b0;
  logic [2:0]  ph = '0;  // pin seen at edges j-1, j-2, j-3

  // driver: apply stimulus at negedge, predict state after next posedge
  task automatic step(input string tag);
    exp_t e;
    logic cap_ev, wrap;
    @(negedge clk);
    cur = nx;
    cap_ev = cur.run & cur.cen & cur.mode & ph[2] & ~ph[1];
    if (cap_ev) m_cap = m_cnt;
    wrap = 1'b0;
    if (cur.run && cur.tick) begin
      if (cur.dec) begin wrap = (m_cnt == 16'h0000); m_cnt = m_cnt - 16'd1; end
      else         begin wrap = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 16'd1; end
    end
    m_wf = wrap | (m_wf & ~cur.wclr);
    m_cf = cap_ev | (m_cf & ~cur.cclr);
    ph = {ph[1:0], cur.pin};
    e.tag = tag; e.cnt = m_cnt; e.cap = m_cap; e.wf = m_wf; e.cf = m_cf;
    e.irq = (m_wf & cur.wie) | (m_cf & cur.cie);
    sb_q.push_back(e);
  endtask

  task automatic steps(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // falling edge on the pin: high for 3 cycles, low for 4
  task automatic pin_fall(input string tag);
    nx.pin = 1'b1; steps(tag, 3);
    nx.pin = 1'b0; steps(tag, 4);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        total++;
        if (count !== e.cnt || cap_val !== e.cap || wrap_flag !== e.wf ||
            cap_flag !== e.cf || irq !== e.irq) begin
          bad++;
          $display("FAIL %s: act cnt=%h cap=%h wf=%b cf=%b irq=%b exp cnt=%h cap=%h wf=%b cf=%b irq=%b",
                   e.tag, count, cap_val, wrap_flag, cap_flag, irq,
                   e.cnt, e.cap, e.wf, e.cf, e.irq);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    nx = '0;
    cur = '0;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    total++;
    if (count !== 16'h0 || cap_val !== 16'h0 || wrap_flag !== 1'b0 ||
        cap_flag !== 1'b0 || irq !== 1'b0) begin
      bad++;
      $display("FAIL R10: act cnt=%h cap=%h wf=%b cf=%b irq=%b exp all zero",
               count, cap_val, wrap_flag, cap_flag, irq);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R11: pin low from reset, capture path armed, no capture
    nx.run = 1; nx.cen = 1; nx.mode = 1; nx.pin = 0;
    steps("R11 low pin from reset", 3);

    // R1 counting patterns
    nx.tick = 1; steps("R1 up", 5);
    for (int i = 0; i < 4; i++) begin nx.tick = i[0]; step("R1 up gapped"); end
    nx.dec = 1; nx.tick = 1; steps("R1 down", 3);

    // R7 halt
    nx.run = 0; steps("R7 halt", 3);

    // R3 underflow, R8 irq with enable
    nx.run = 1; nx.wie = 1; steps("R1 down to zero", 4);
    steps("R3 underflow", 1);
    nx.tick = 0; steps("R8 wrap irq", 2);
    nx.wclr = 1; steps("R9 clear", 1);
    nx.wclr = 0; steps("R9 cleared", 1);

    // R2 overflow
    nx.dec = 0; nx.tick = 1; steps("R2 overflow", 1);
    nx.tick = 0; steps("R2 held", 1);

    // R9 set wins over clear
    nx.dec = 1; nx.tick = 1; nx.wclr = 1; steps("R9 set wins", 1);
    nx.tick = 0; steps("R9 clear after", 1);
    nx.wclr = 0;

    // R4 capture with tick every cycle
    nx.dec = 0; nx.tick = 1; nx.cie = 1;
    pin_fall("R4 capture with tick");
    nx.cclr = 1; steps("R9 cap clear", 1);
    nx.cclr = 0;

    // R6 capture disabled
    nx.cen = 0; pin_fall("R6 cap disabled");
    // R7 wrong mode, then run off
    nx.cen = 1; nx.mode = 0; pin_fall("R7 mode off");
    nx.mode = 1; nx.run = 0; pin_fall("R7 run off");

    // R5 two captures, second overwrites while flag set
    nx.run = 1; nx.dec = 1;
    pin_fall("R5 first capture");
    nx.tick = 0; steps("R5 idle", 2);
    nx.tick = 1; pin_fall("R5 overwrite");

    // R9 capture with clear in same cycle
    nx.pin = 1; steps("R9 cap set wins", 3);
    nx.pin = 0; steps("R9 cap set wins", 2);
    nx.cclr = 1; steps("R9 cap set wins", 1);
    nx.cclr = 0; steps("R9 cap set wins", 1);

    // R8 masked
    nx.wie = 0; nx.cie = 0; steps("R8 masked", 2);
    nx.cie = 1; steps("R8 cap only", 1);

    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule